// File: doc/BRIEF.md
# Keyed SDRAM Command Port

This block lets software drive single low-level operations on an external SDRAM through a small register bus. Software first loads the target address, then the outgoing data and the transfer size if it needs them, and finally writes a command word. The upper half of the command word must carry a fixed unlock key. The low nibble selects the operation. When a command is accepted, the block raises a request toward the SDRAM pin sequencer. The request carries the code, the address, the data and the size, all frozen at the moment of acceptance. The request stays raised until the sequencer acknowledges it.

Each acknowledge sets a sticky done flag. A read also loads the word returned by the sequencer into a receive register. A command word with a wrong key, a code outside the software set, a missing fresh address, or a command word that arrives while an earlier command is still pending sets a sticky error flag instead and sends nothing downstream. Software clears either flag by writing a one to its bit.

Register offsets (word index on `regAddr`): 0 target address, 1 transfer size, 2 transmit data, 3 command word, 4 receive data, 5 status.

Top module: `sdcmd_port`

## Requirements
- R1: After reset the status register (offset 5) reads 0, the size register (offset 1) reads 2, the receive register (offset 4) reads 0 and `seqReq` is low.
- R2: A command word is accepted only when bits 31:16 equal 0xA55A. Bits 15:4 are ignored. Any other key sets the error flag (status bit 1) and raises no request.
- R3: The code in bits 3:0 must lie in 0x8..0xF (0x8 read, 0x9 write, 0xA mode set, 0xB activate, 0xC refresh, 0xD self refresh, 0xE precharge, 0xF precharge all). An accepted code appears unchanged on `seqCode`. Codes 0x0..0x7 set the error flag and raise no request.
- R4: A command is accepted only if the address register was written after the last accepted command. Otherwise the error flag is set and no request is raised.
- R5: On acceptance, `seqReq` rises in the next cycle. `seqAddr`, `seqWdata` and `seqSize` then carry the address, transmit and size registers as they stood at acceptance. All request outputs hold steady until `seqAck`, even if those registers are rewritten meanwhile.
- R6: In the cycle after `seqAck` is sampled high with `seqReq` high, `seqReq` is low and the done flag (status bit 0) is set.
- R7: Completion of a read (code 0x8) loads `seqRdata` into the receive register. Completion of any other code leaves it unchanged.
- R8: A command word written while a request is pending sets the error flag. It raises no second request and alters none of the pending request's outputs.
- R9: The status flags are sticky. Writing 1 to a status bit clears it and writing 0 leaves it. If a flag is set and cleared in the same cycle, it ends up set.
- R10: The address, size and transmit registers read back the values written. The command word offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 3 | Register word offset |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational on regAddr) |
| seqReq | output | 1 | Command request to the sequencer |
| seqCode | output | 4 | Command code of the pending request |
| seqAddr | output | ADDR_W | Target address of the pending request |
| seqWdata | output | 32 | Outgoing data of the pending request |
| seqSize | output | SIZE_W | Transfer size of the pending request |
| seqAck | input | 1 | Sequencer completion pulse |
| seqRdata | input | 32 | Word returned by the sequencer |

## Verification
A sequencer acknowledge and a software write-one-to-clear of the done flag can land on the same clock edge. To provoke this, the bench leaves the done flag set from an earlier command, holds back its sequencer model, and then drives `seqAck` and a status write of 1 in the same cycle. The flag must read back set. A second overlap is a command write that arrives while a request is pending. The bench judges it by the error flag, by the pending request's fields staying put, and by the absence of any new request edge in the request scoreboard.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam int BUS_W = 32;
  localparam int REG_AW = 3;
  localparam logic [15:0] UNLOCK_KEY = 16'hA55A;
  localparam logic [3:0] CODE_READ = 4'h8;

  localparam logic [REG_AW-1:0] OFS_ADDR = 3'd0;
  localparam logic [REG_AW-1:0] OFS_SIZE = 3'd1;
  localparam logic [REG_AW-1:0] OFS_TX   = 3'd2;
  localparam logic [REG_AW-1:0] OFS_CMD  = 3'd3;
  localparam logic [REG_AW-1:0] OFS_RX   = 3'd4;
  localparam logic [REG_AW-1:0] OFS_STAT = 3'd5;

  typedef struct packed {
    logic issue;    // latch request fields, consume address arming
    logic capture;  // load receive register
    logic setDone;
    logic setErr;
  } ctrlStrobe_t;
endpackage

// File: rtl/sdcmd_ctrl.sv
module sdcmd_ctrl
  import sdcmd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWrite,
  input  logic [15:0] cmdKey,
  input  logic [3:0]  cmdCode,
  input  logic        addrArmed,
  input  logic        seqAck,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic [3:0]  codeQ
);
  logic keyOk, codeOk, accept, complete;

  assign keyOk    = (cmdKey == UNLOCK_KEY);
  assign codeOk   = cmdCode[3];
  assign accept   = cmdWrite && !busy && keyOk && codeOk && addrArmed;
  assign complete = busy && seqAck;

  always_comb begin
    strobe.issue   = accept;
    strobe.capture = complete && (codeQ == CODE_READ);
    strobe.setDone = complete;
    strobe.setErr  = cmdWrite && !accept;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy  <= 1'b0;
      codeQ <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      codeQ <= cmdCode;
    end else if (complete) begin
      busy  <= 1'b0;
    end
  end

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !seqAck |=> busy);
  // R6
  req_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && seqAck |=> !busy);
  // R3
  code_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> codeQ[3]);
  // R8
  code_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !seqAck |=> $stable(codeQ));
endmodule

// File: rtl/sdcmd_dpath.sv
module sdcmd_dpath
  import sdcmd_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SIZE_W   = 4,
  parameter int SIZE_RST = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWe,
  input  logic [BUS_W-1:0]  regWdata,
  output logic [BUS_W-1:0]  regRdata,
  input  ctrlStrobe_t       strobe,
  input  logic              pending,
  input  logic [BUS_W-1:0]  seqRdata,
  output logic              addrArmed,
  output logic [ADDR_W-1:0] seqAddr,
  output logic [BUS_W-1:0]  seqWdata,
  output logic [SIZE_W-1:0] seqSize
);
  logic [ADDR_W-1:0] addrQ;
  logic [SIZE_W-1:0] sizeQ;
  logic [BUS_W-1:0]  txQ, rxQ;
  logic              doneQ, errQ;
  logic              wrAddr, wrSize, wrTx, wrStat;

  assign wrAddr = regWe && (regAddr == OFS_ADDR);
  assign wrSize = regWe && (regAddr == OFS_SIZE);
  assign wrTx   = regWe && (regAddr == OFS_TX);
  assign wrStat = regWe && (regAddr == OFS_STAT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ     <= '0;
      sizeQ     <= SIZE_W'(SIZE_RST);
      txQ       <= '0;
      rxQ       <= '0;
      addrArmed <= 1'b0;
      seqAddr   <= '0;
      seqWdata  <= '0;
      seqSize   <= '0;
      doneQ     <= 1'b0;
      errQ      <= 1'b0;
    end else begin
      if (wrAddr) addrQ <= regWdata[ADDR_W-1:0];
      if (wrSize) sizeQ <= regWdata[SIZE_W-1:0];
      if (wrTx)   txQ   <= regWdata;
      if (strobe.issue) begin
        addrArmed <= 1'b0;
        seqAddr   <= addrQ;
        seqWdata  <= txQ;
        seqSize   <= sizeQ;
      end else if (wrAddr) begin
        addrArmed <= 1'b1;
      end
      if (strobe.capture) rxQ <= seqRdata;
      // set has priority over write-one-to-clear
      doneQ <= strobe.setDone | (doneQ & ~(wrStat & regWdata[0]));
      errQ  <= strobe.setErr  | (errQ  & ~(wrStat & regWdata[1]));
    end
  end

  always_comb begin
    case (regAddr)
      OFS_ADDR: regRdata = BUS_W'(addrQ);
      OFS_SIZE: regRdata = BUS_W'(sizeQ);
      OFS_TX:   regRdata = txQ;
      OFS_RX:   regRdata = rxQ;
      OFS_STAT: regRdata = {{(BUS_W-2){1'b0}}, errQ, doneQ};
      default:  regRdata = '0;
    endcase
  end

  // R6
  done_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setDone |=> doneQ);
  // R2
  err_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setErr |=> errQ);
  // R5
  fields_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    pending |=> $stable(seqAddr) && $stable(seqWdata) && $stable(seqSize));
  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneQ && !(wrStat && regWdata[0]) |=> doneQ);
endmodule

// File: rtl/sdcmd_port.sv
module sdcmd_port
  import sdcmd_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SIZE_W   = 4,
  parameter int SIZE_RST = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        regAddr,
  input  logic              regWe,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              seqReq,
  output logic [3:0]        seqCode,
  output logic [ADDR_W-1:0] seqAddr,
  output logic [31:0]       seqWdata,
  output logic [SIZE_W-1:0] seqSize,
  input  logic              seqAck,
  input  logic [31:0]       seqRdata
);
  ctrlStrobe_t strobe;
  logic        addrArmed;

  sdcmd_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdWrite (regWe && (regAddr == OFS_CMD)),
    .cmdKey   (regWdata[31:16]),
    .cmdCode  (regWdata[3:0]),
    .addrArmed(addrArmed),
    .seqAck   (seqAck),
    .strobe   (strobe),
    .busy     (seqReq),
    .codeQ    (seqCode)
  );

  sdcmd_dpath #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .SIZE_RST(SIZE_RST)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWe    (regWe),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .strobe   (strobe),
    .pending  (seqReq),
    .seqRdata (seqRdata),
    .addrArmed(addrArmed),
    .seqAddr  (seqAddr),
    .seqWdata (seqWdata),
    .seqSize  (seqSize)
  );
endmodule

// File: tb/tb_sdcmd_port.sv
module tb_sdcmd_port;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        seqReq;
  logic [3:0]  seqCode;
  logic [31:0] seqAddr;
  logic [31:0] seqWdata;
  logic [3:0]  seqSize;
  logic        seqAck = 1'b0;
  logic [31:0] seqRdata = '0;

  always #10 clk = ~clk;  // 50 MHz

  sdcmd_port dut (.*);

  typedef struct { logic [2:0] ofs; logic [31:0] exp; string tag; } rdItem_t;
  typedef struct { logic [95:0] fields; string tag; } reqItem_t;

  rdItem_t  rdQ[$];
  reqItem_t reqQ[$];
  int vectors = 0, miscompares = 0;
  bit rdProbe = 0, prevReq = 0, ackHold = 0, done = 0;
  int ackDelay = 2;
  logic [31:0] rdWord = 32'h0;

  task automatic note(bit ok, string tag, logic [95:0] act, logic [95:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); regAddr = a; regWe = 1'b1; regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] e, string tag);
    rdItem_t it;
    @(negedge clk); regAddr = a;
    it.ofs = a; it.exp = e; it.tag = tag;
    rdQ.push_back(it);
    rdProbe = 1'b1;
    @(negedge clk); rdProbe = 1'b0;
  endtask

  task automatic cmd(logic [15:0] key, logic [3:0] code);
    wr(3'd3, {key, 12'h0, code});
  endtask

  task automatic expectReq(logic [3:0] c, logic [31:0] a, logic [31:0] d,
                           logic [3:0] s, string tag);
    reqItem_t it;
    it.fields = {c, a, d, 24'h0, s};
    it.tag = tag;
    reqQ.push_back(it);
  endtask

  task automatic waitIdle(string tag);
    int n = 0;
    do begin @(negedge clk); n++; end while (seqReq && n < 500);
    note(!seqReq, tag, {95'h0, seqReq}, 96'h0);
  endtask

  // monitor: pops expected reads and requests as the design produces them
  initial forever begin
    rdItem_t ri;
    reqItem_t qi;
    logic [95:0] got;
    @(negedge clk); #5;
    if (rdProbe && rdQ.size() > 0) begin
      ri = rdQ.pop_front();
      note(regRdata === ri.exp, ri.tag, {64'h0, regRdata}, {64'h0, ri.exp});
    end
    if (rstN && seqReq && !prevReq) begin
      got = {seqCode, seqAddr, seqWdata, 24'h0, seqSize};
      if (reqQ.size() == 0) note(1'b0, "R8 unexpected request", got, 96'h0);
      else begin
        qi = reqQ.pop_front();
        note(got === qi.fields, qi.tag, got, qi.fields);
      end
    end
    prevReq = seqReq;
  end

  // sequencer model
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (!ackHold) begin
        seqAck = 1'b0;
        if (seqReq) begin
          cnt++;
          if (cnt >= ackDelay) begin seqAck = 1'b1; seqRdata = rdWord; cnt = 0; end
        end else cnt = 0;
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      note(1'b0, "watchdog", 96'h0, 96'h1);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    note(!seqReq, "R1 seqReq after reset", {95'h0, seqReq}, 96'h0);
    rd(3'd5, 32'h0, "R1 status reset");
    rd(3'd1, 32'h2, "R1 size reset");
    rd(3'd4, 32'h0, "R1 rx reset");
    // R10 readback
    wr(3'd0, 32'h0000_1000); rd(3'd0, 32'h0000_1000, "R10 addr readback");
    wr(3'd2, 32'hDEAD_BEEF); rd(3'd2, 32'hDEAD_BEEF, "R10 tx readback");
    wr(3'd1, 32'h5);         rd(3'd1, 32'h5, "R10 size readback");
    rd(3'd3, 32'h0, "R10 cmd reads zero");
    // write command
    expectReq(4'h9, 32'h1000, 32'hDEAD_BEEF, 4'h5, "R5 write request fields");
    cmd(16'hA55A, 4'h9);
    waitIdle("R6 request released");
    rd(3'd5, 32'h1, "R6 done set");
    rd(3'd4, 32'h0, "R7 write leaves rx");
    wr(3'd5, 32'h0); rd(3'd5, 32'h1, "R9 zero write keeps");
    wr(3'd5, 32'h1); rd(3'd5, 32'h0, "R9 one write clears");
    // read command
    rdWord = 32'h1234_5678;
    wr(3'd0, 32'h0000_2000);
    expectReq(4'h8, 32'h2000, 32'hDEAD_BEEF, 4'h5, "R5 read request fields");
    cmd(16'hA55A, 4'h8);
    waitIdle("R6 read released");
    rd(3'd4, 32'h1234_5678, "R7 read captured");
    rd(3'd5, 32'h1, "R6 read done");
    wr(3'd5, 32'h1);
    // key and code rejects
    wr(3'd0, 32'h0000_3000);
    cmd(16'h1234, 4'h9);
    rd(3'd5, 32'h2, "R2 bad key error");
    wr(3'd5, 32'h2); rd(3'd5, 32'h0, "R9 err cleared");
    cmd(16'hA55A, 4'h1); rd(3'd5, 32'h2, "R3 reserved code 1"); wr(3'd5, 32'h2);
    cmd(16'hA55A, 4'h5); rd(3'd5, 32'h2, "R3 invalid code 5"); wr(3'd5, 32'h2);
    // middle bits ignored, refresh accepted
    expectReq(4'hC, 32'h3000, 32'hDEAD_BEEF, 4'h5, "R3 refresh request");
    wr(3'd3, 32'hA55A_FF0C);
    waitIdle("R6 refresh released");
    rd(3'd5, 32'h1, "R2 middle bits ignored");
    rd(3'd4, 32'h1234_5678, "R7 refresh leaves rx");
    wr(3'd5, 32'h1);
    // no fresh address
    cmd(16'hA55A, 4'hE);
    rd(3'd5, 32'h2, "R4 stale address error");
    wr(3'd5, 32'h2);
    // command while pending
    ackDelay = 30;
    wr(3'd0, 32'h0000_4000); wr(3'd2, 32'h0000_1111); wr(3'd1, 32'h3);
    expectReq(4'hA, 32'h4000, 32'h1111, 4'h3, "R5 mode set request");
    cmd(16'hA55A, 4'hA);
    wr(3'd0, 32'h0000_5555); wr(3'd2, 32'h0000_2222);
    cmd(16'hA55A, 4'hB);
    @(negedge clk);
    note(seqReq && seqAddr == 32'h4000 && seqWdata == 32'h1111 && seqSize == 4'h3
         && seqCode == 4'hA, "R8 pending request unchanged",
         {seqCode, seqAddr, seqWdata, 24'h0, seqSize}, {4'hA, 32'h4000, 32'h1111, 24'h0, 4'h3});
    rd(3'd5, 32'h2, "R8 error while pending");
    waitIdle("R6 mode set released");
    rd(3'd5, 32'h3, "R8 done and error");
    ackDelay = 1;
    wr(3'd5, 32'h2);
    rd(3'd5, 32'h1, "R9 selective clear");
    // set and clear of done in the same cycle
    expectReq(4'hD, 32'h5555, 32'h2222, 4'h3, "R5 self refresh request");
    ackHold = 1'b1;
    cmd(16'hA55A, 4'hD);
    @(negedge clk);
    seqAck = 1'b1; regAddr = 3'd5; regWe = 1'b1; regWdata = 32'h1;
    @(negedge clk);
    seqAck = 1'b0; regWe = 1'b0; ackHold = 1'b0;
    note(!seqReq, "R6 released on collision", {95'h0, seqReq}, 96'h0);
    rd(3'd5, 32'h1, "R9 set wins over clear");
    wr(3'd5, 32'h1); rd(3'd5, 32'h0, "R9 final clear");
    repeat (3) @(negedge clk);
    note(reqQ.size() == 0, "R5 all expected requests seen", 96'(reqQ.size()), 96'h0);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule